// File: doc/BRIEF.md
# Floppy Drive Mechanical Delay Timers

This block times the three mechanical waits a floppy disk controller needs. The first is the gap between head step pulses during a seek. The second is the settle time after the head is loaded. The third is the idle delay before the head is unloaded. The controller's command sequencer supplies three things: a 4-bit step code, a 4-bit unload code and a 7-bit load code. It also supplies a data-rate select and a few strobes. The block returns a done pulse and a busy flag for each timer, the head-loaded state, a drive-polling permit and a one-time polling interrupt request.

Each interval is first worked out in milliseconds at 500 kbit/s. It is then converted into ticks of 1/12 ms, using the multiple for the selected rate. All three timers count this tick, so every rate is exact, including the 5/3 factor at 300 kbit/s. The number of system clocks in one tick is the parameter `TICK_CLKS`. The block moves no data stream, so it has no valid/ready pair. Every pin is a plain control or status level, or a one-cycle strobe, and the block applies no back-pressure.

Top module: `fdt_mech_timer`

## Requirements
- R1: A synchronous active-high reset stops all three timers, drives `head_loaded` low and raises the post-reset polling request, so `poll_irq` is high in the first cycle after reset whenever `poll_en` is high.
- R2: While `seek_active` is high, `step_pulse` fires once every (16 - `srt_code`) ms, scaled per R3. The first pulse comes one interval after the first clock edge that sees `seek_active` high. When `seek_active` goes low, the step timer stops and `step_busy` falls after the next edge.
- R3: `rate_sel` selects how many 1/12 ms ticks make one 500 kbit/s millisecond: 0 = 500 kbit/s (12), 1 = 300 kbit/s (20), 2 = 250 kbit/s (24), 3 = 1 Mbit/s (6), 4 = 2 Mbit/s (3). Codes 5 to 7 behave as code 0. A delay lasts (ms × ticks × `TICK_CLKS`) clock cycles.
- R4: A `load_req` strobe when the head is unloaded raises `head_loaded` and starts the load timer. `load_done` pulses for one cycle (`hlt_code` × 2) ms later, and a code of 0 counts as 128.
- R5: A `load_req` strobe when the head is loaded and no load settle is running cancels any running unload delay. The head stays loaded, and `load_done` pulses in the cycle after the strobe.
- R6: A `head_release` strobe when the head is loaded starts the unload timer. `unload_done` pulses (`hut_code` × 16) ms later, and a code of 0 counts as 16. `head_loaded` is low in the following cycle unless `load_req` is present in the pulse cycle.
- R7: `head_release` is ignored when the head is not loaded, while a load settle is running, or while an unload delay is already running.
- R8: `poll_ok` equals `poll_en` and not `head_loaded`. Polling is therefore refused for the whole time the head is loaded, including the unload delay.
- R9: The post-reset polling request is cleared by `irq_ack` and is not raised again until the next reset. `poll_irq` is the request gated by `poll_en`.
- R10: Codes and the rate are read only when a timer starts. A change during an interval does not alter that interval. For the step timer, each automatic restart at a pulse counts as a start.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| rate_sel | input | 3 | Data-rate select (R3 encoding) |
| srt_code | input | 4 | Step interval code |
| hut_code | input | 4 | Head unload delay code |
| hlt_code | input | 7 | Head load settle code |
| poll_en | input | 1 | Drive polling enabled |
| seek_active | input | 1 | Level: a seek wants step pulses |
| load_req | input | 1 | Strobe: an access needs the head |
| head_release | input | 1 | Strobe: the head has gone idle |
| irq_ack | input | 1 | Strobe: clears the post-reset polling request |
| step_pulse | output | 1 | One-cycle pulse per step interval |
| step_busy | output | 1 | Step timer running |
| load_done | output | 1 | One-cycle pulse: head load settled |
| load_busy | output | 1 | Load settle running |
| unload_done | output | 1 | One-cycle pulse: unload delay expired |
| unload_busy | output | 1 | Unload delay running |
| head_loaded | output | 1 | Head is loaded |
| poll_ok | output | 1 | Drive polling permitted |
| poll_irq | output | 1 | Post-reset polling interrupt request |

## Verification
Each interval is measured with codes at both ends of its range and at least one in the middle. The zero codes that stand for 16 or 128 units are included, so a wrong mapping for zero separates from a plain off-by-one. The measurements are taken under several rates, including 300 kbit/s and an unused rate code, which tells a wrong per-rate multiple apart from a wrong unit size. The step timer is changed mid-interval to show that the running period is kept and the next one uses the new code. The head sequence covers four cases: a cold load, a load during the unload delay, a release that must be ignored, and the polling permit and interrupt around those states.

// File: rtl/fdt_pkg.sv
package fdt_pkg;

  // Width of a tick count: the longest delay is 256 ms x 24 ticks = 6144.
  localparam int TICKS_W = 13;

  typedef enum logic [2:0] {
    RATE_500K = 3'd0,
    RATE_300K = 3'd1,
    RATE_250K = 3'd2,
    RATE_1M   = 3'd3,
    RATE_2M   = 3'd4
  } rate_e;

  // Ticks of 1/12 ms in one millisecond of the 500 kbit/s time base.
  function automatic logic [4:0] ticks_per_ms(input logic [2:0] rate);
    case (rate)
      RATE_300K: ticks_per_ms = 5'd20;
      RATE_250K: ticks_per_ms = 5'd24;
      RATE_1M:   ticks_per_ms = 5'd6;
      RATE_2M:   ticks_per_ms = 5'd3;
      default:   ticks_per_ms = 5'd12;
    endcase
  endfunction

endpackage

// File: rtl/fdt_interval.sv
module fdt_interval
  import fdt_pkg::*;
#(
  parameter int TW = TICKS_W
) (
  input  logic [2:0]    rate_sel,
  input  logic [3:0]    srt_code,
  input  logic [3:0]    hut_code,
  input  logic [6:0]    hlt_code,
  output logic [TW-1:0] step_ticks,
  output logic [TW-1:0] load_ticks,
  output logic [TW-1:0] unload_ticks
);

  logic [4:0] tpm;
  logic [4:0] step_ms;     // 1 .. 16
  logic [8:0] unload_ms;   // 16 .. 256
  logic [8:0] load_ms;     // 2 .. 256

  always_comb begin
    tpm       = ticks_per_ms(rate_sel);
    step_ms   = 5'd16 - {1'b0, srt_code};
    unload_ms = (hut_code == 4'd0) ? 9'd256 : {1'b0, hut_code, 4'b0000};
    load_ms   = (hlt_code == 7'd0) ? 9'd256 : {1'b0, hlt_code, 1'b0};
  end

  assign step_ticks   = TW'(step_ms)   * TW'(tpm);
  assign unload_ticks = TW'(unload_ms) * TW'(tpm);
  assign load_ticks   = TW'(load_ms)   * TW'(tpm);

endmodule

// File: rtl/fdt_countdown.sv
module fdt_countdown #(
  parameter int CW  = 13,
  parameter int DIV = 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic          cancel,
  input  logic          reload_en,
  input  logic [CW-1:0] ticks,
  output logic          busy,
  output logic          done
);

  localparam int SW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [SW-1:0] SUB_TOP = SW'(DIV - 1);

  logic [SW-1:0] sub;
  logic [CW-1:0] cnt;
  logic          tick;

  assign tick = busy && (sub == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0;
      done <= 1'b0;
      sub  <= '0;
      cnt  <= '0;
    end else begin
      done <= 1'b0;
      if (cancel) begin
        busy <= 1'b0;
      end else if (start) begin
        busy <= 1'b1;
        sub  <= SUB_TOP;
        cnt  <= ticks;
      end else if (busy) begin
        if (tick) begin
          sub <= SUB_TOP;
          if (cnt == CW'(1)) begin
            done <= 1'b1;
            if (reload_en) cnt <= ticks;
            else           busy <= 1'b0;
          end else begin
            cnt <= cnt - CW'(1);
          end
        end else begin
          sub <= sub - SW'(1);
        end
      end
    end
  end

endmodule

// File: rtl/fdt_head_ctl.sv
module fdt_head_ctl (
  input  logic clk,
  input  logic rst,
  input  logic load_req,
  input  logic head_release,
  input  logic load_busy,
  input  logic unload_busy,
  input  logic unload_expired,
  output logic load_start,
  output logic unload_start,
  output logic unload_cancel,
  output logic quick_done,
  output logic head_loaded
);

  logic reuse;

  assign load_start    = load_req & ~head_loaded;
  assign reuse         = load_req & head_loaded & ~load_busy;
  assign unload_cancel = reuse & unload_busy;
  assign unload_start  = head_release & head_loaded & ~load_busy & ~unload_busy
                       & ~unload_expired & ~load_req;

  always_ff @(posedge clk) begin
    if (rst) begin
      head_loaded <= 1'b0;
      quick_done  <= 1'b0;
    end else begin
      quick_done <= reuse;
      if (load_start)
        head_loaded <= 1'b1;
      else if (unload_expired && !load_req)
        head_loaded <= 1'b0;
    end
  end

endmodule

// File: rtl/fdt_poll.sv
module fdt_poll (
  input  logic clk,
  input  logic rst,
  input  logic poll_en,
  input  logic head_loaded,
  input  logic irq_ack,
  output logic poll_ok,
  output logic poll_irq
);

  logic pending;

  always_ff @(posedge clk) begin
    if (rst)          pending <= 1'b1;
    else if (irq_ack) pending <= 1'b0;
  end

  assign poll_ok  = poll_en & ~head_loaded;
  assign poll_irq = poll_en & pending;

endmodule

// File: rtl/fdt_mech_timer.sv
module fdt_mech_timer
  import fdt_pkg::*;
#(
  parameter int TICK_CLKS = 4000
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [2:0] rate_sel,
  input  logic [3:0] srt_code,
  input  logic [3:0] hut_code,
  input  logic [6:0] hlt_code,
  input  logic       poll_en,
  input  logic       seek_active,
  input  logic       load_req,
  input  logic       head_release,
  input  logic       irq_ack,
  output logic       step_pulse,
  output logic       step_busy,
  output logic       load_done,
  output logic       load_busy,
  output logic       unload_done,
  output logic       unload_busy,
  output logic       head_loaded,
  output logic       poll_ok,
  output logic       poll_irq
);

  localparam int TW       = TICKS_W;
  localparam int N_TIMERS = 3;
  localparam int I_STEP   = 0;
  localparam int I_LOAD   = 1;
  localparam int I_UNLOAD = 2;

  logic [TW-1:0]       t_ticks [N_TIMERS];
  logic [N_TIMERS-1:0] t_start, t_cancel, t_reload, t_busy, t_done;

  logic ld_start, ul_start, ul_cancel, quick_done;

  fdt_interval #(.TW(TW)) u_interval (
    .rate_sel     (rate_sel),
    .srt_code     (srt_code),
    .hut_code     (hut_code),
    .hlt_code     (hlt_code),
    .step_ticks   (t_ticks[I_STEP]),
    .load_ticks   (t_ticks[I_LOAD]),
    .unload_ticks (t_ticks[I_UNLOAD])
  );

  fdt_head_ctl u_head (
    .clk            (clk),
    .rst            (rst),
    .load_req       (load_req),
    .head_release   (head_release),
    .load_busy      (t_busy[I_LOAD]),
    .unload_busy    (t_busy[I_UNLOAD]),
    .unload_expired (t_done[I_UNLOAD]),
    .load_start     (ld_start),
    .unload_start   (ul_start),
    .unload_cancel  (ul_cancel),
    .quick_done     (quick_done),
    .head_loaded    (head_loaded)
  );

  always_comb begin
    t_start[I_STEP]    = seek_active & ~t_busy[I_STEP];
    t_cancel[I_STEP]   = ~seek_active;
    t_reload[I_STEP]   = seek_active;
    t_start[I_LOAD]    = ld_start;
    t_cancel[I_LOAD]   = 1'b0;
    t_reload[I_LOAD]   = 1'b0;
    t_start[I_UNLOAD]  = ul_start;
    t_cancel[I_UNLOAD] = ul_cancel;
    t_reload[I_UNLOAD] = 1'b0;
  end

  for (genvar gi = 0; gi < N_TIMERS; gi++) begin : g_timer
    fdt_countdown #(.CW(TW), .DIV(TICK_CLKS)) u_cd (
      .clk       (clk),
      .rst       (rst),
      .start     (t_start[gi]),
      .cancel    (t_cancel[gi]),
      .reload_en (t_reload[gi]),
      .ticks     (t_ticks[gi]),
      .busy      (t_busy[gi]),
      .done      (t_done[gi])
    );
  end

  fdt_poll u_poll (
    .clk         (clk),
    .rst         (rst),
    .poll_en     (poll_en),
    .head_loaded (head_loaded),
    .irq_ack     (irq_ack),
    .poll_ok     (poll_ok),
    .poll_irq    (poll_irq)
  );

  assign step_pulse  = t_done[I_STEP];
  assign step_busy   = t_busy[I_STEP];
  assign load_done   = t_done[I_LOAD] | quick_done;
  assign load_busy   = t_busy[I_LOAD];
  assign unload_done = t_done[I_UNLOAD];
  assign unload_busy = t_busy[I_UNLOAD];

endmodule

// File: rtl/fdt_mech_timer_chk.sv
module fdt_mech_timer_chk (
  input logic clk,
  input logic rst,
  input logic poll_en,
  input logic seek_active,
  input logic load_req,
  input logic step_pulse,
  input logic step_busy,
  input logic load_done,
  input logic load_busy,
  input logic unload_done,
  input logic unload_busy,
  input logic head_loaded,
  input logic poll_ok,
  input logic poll_irq
);

  p_reset_clear_r1: assert property (@(posedge clk)
    rst |=> (!head_loaded && !load_busy && !unload_busy && !step_busy));

  p_step_in_seek_r2: assert property (@(posedge clk) disable iff (rst)
    step_pulse |-> ($past(seek_active) && step_busy));

  p_load_done_loaded_r4: assert property (@(posedge clk) disable iff (rst)
    load_done |-> head_loaded);

  p_unload_clears_r6: assert property (@(posedge clk) disable iff (rst)
    (unload_done && !load_req) |=> !head_loaded);

  p_unload_needs_head_r7: assert property (@(posedge clk) disable iff (rst)
    unload_busy |-> head_loaded);

  p_poll_gate_r8: assert property (@(posedge clk) disable iff (rst)
    head_loaded |-> !poll_ok);

  p_irq_once_r9: assert property (@(posedge clk) disable iff (rst)
    (!poll_irq && poll_en) |=> (!poll_irq || !poll_en));

endmodule

bind fdt_mech_timer fdt_mech_timer_chk u_chk (
  .clk         (clk),
  .rst         (rst),
  .poll_en     (poll_en),
  .seek_active (seek_active),
  .load_req    (load_req),
  .step_pulse  (step_pulse),
  .step_busy   (step_busy),
  .load_done   (load_done),
  .load_busy   (load_busy),
  .unload_done (unload_done),
  .unload_busy (unload_busy),
  .head_loaded (head_loaded),
  .poll_ok     (poll_ok),
  .poll_irq    (poll_irq)
);

// File: tb/sim_fdt_mech_timer.sv
module sim_fdt_mech_timer;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [2:0] rate_sel = 3'd0;
  logic [3:0] srt_code = 4'hF;
  logic [3:0] hut_code = 4'hF;
  logic [6:0] hlt_code = 7'h01;
  logic poll_en = 1'b1, seek_active = 1'b0, load_req = 1'b0;
  logic head_release = 1'b0, irq_ack = 1'b0;
  logic step_pulse, step_busy, load_done, load_busy;
  logic unload_done, unload_busy, head_loaded, poll_ok, poll_irq;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  fdt_mech_timer #(.TICK_CLKS(1)) u0 (
    .clk(clk), .rst(rst), .rate_sel(rate_sel), .srt_code(srt_code),
    .hut_code(hut_code), .hlt_code(hlt_code), .poll_en(poll_en),
    .seek_active(seek_active), .load_req(load_req),
    .head_release(head_release), .irq_ack(irq_ack),
    .step_pulse(step_pulse), .step_busy(step_busy), .load_done(load_done),
    .load_busy(load_busy), .unload_done(unload_done),
    .unload_busy(unload_busy), .head_loaded(head_loaded),
    .poll_ok(poll_ok), .poll_irq(poll_irq)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic pick(input int which);
    case (which)
      0:       pick = step_pulse;
      1:       pick = load_done;
      default: pick = unload_done;
    endcase
  endfunction

  // Counts falling edges until the chosen pulse is seen.
  task automatic measure(input int which, output int n);
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!pick(which) && n < 8000);
  endtask

  task automatic strobe_load();
    load_req = 1'b1;
    @(negedge clk);
    load_req = 1'b0;
  endtask

  task automatic strobe_release();
    head_release = 1'b1;
    @(negedge clk);
    head_release = 1'b0;
  endtask

  task automatic t_reset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 head_loaded", head_loaded, 0);
    chk("R1 busy flags", {step_busy, load_busy, unload_busy}, 0);
    chk("R1 poll_irq raised", poll_irq, 1);
    chk("R8 poll_ok idle", poll_ok, 1);
  endtask

  task automatic t_step(input logic [2:0] rate, input logic [3:0] code,
                        input int exp, input string tag);
    int n;
    rate_sel = rate;
    srt_code = code;
    seek_active = 1'b1;
    @(negedge clk);
    measure(0, n);
    chk({tag, " first step"}, n, exp);
    measure(0, n);
    chk({tag, " step period"}, n, exp);
    seek_active = 1'b0;
    @(negedge clk);
    chk("R2 step stops", step_busy, 0);
  endtask

  task automatic t_step_change();
    int n;
    rate_sel = 3'd0;
    srt_code = 4'hF;
    seek_active = 1'b1;
    @(negedge clk);
    measure(0, n);
    srt_code = 4'hE;
    measure(0, n);
    chk("R10 running period kept", n, 12);
    measure(0, n);
    chk("R10 new code next period", n, 24);
    seek_active = 1'b0;
    n = 0;
    repeat (40) begin
      @(negedge clk);
      if (step_pulse) n++;
    end
    chk("R2 no pulse without seek", n, 0);
  endtask

  task automatic t_load(input logic [2:0] rate, input logic [6:0] code,
                        input int exp, input string tag);
    int n;
    rate_sel = rate;
    hlt_code = code;
    load_req = 1'b1;
    @(negedge clk);
    load_req = 1'b0;
    chk("R4 head_loaded after strobe", head_loaded, 1);
    measure(1, n);
    chk({tag, " load settle"}, n, exp);
    chk("R8 poll refused when loaded", poll_ok, 0);
  endtask

  task automatic t_unload(input logic [2:0] rate, input logic [3:0] code,
                          input int exp, input string tag);
    int n;
    rate_sel = rate;
    hut_code = code;
    head_release = 1'b1;
    @(negedge clk);
    head_release = 1'b0;
    measure(2, n);
    chk({tag, " unload delay"}, n, exp);
    @(negedge clk);
    chk("R6 head drops after unload", head_loaded, 0);
    chk("R8 poll allowed after unload", poll_ok, 1);
  endtask

  task automatic t_reuse();
    rate_sel = 3'd0;
    hut_code = 4'h0;
    strobe_release();
    repeat (100) @(negedge clk);
    chk("R8 poll refused during unload", poll_ok, 0);
    load_req = 1'b1;
    @(negedge clk);
    load_req = 1'b0;
    chk("R5 quick load_done", load_done, 1);
    chk("R5 unload cancelled", unload_busy, 0);
    repeat (3100) @(negedge clk);
    chk("R5 head kept loaded", head_loaded, 1);
  endtask

  task automatic t_release_ignored();
    int n;
    // head unloaded: release must not start anything
    strobe_release();
    chk("R7 release when unloaded", {unload_busy, head_loaded}, 0);
    // release during load settle: 01 at 500 kbit/s is 24 cycles
    rate_sel = 3'd0;
    hlt_code = 7'h01;
    strobe_load();
    strobe_release();
    chk("R7 release during settle", unload_busy, 0);
    measure(1, n);
    chk("R4 settle unaffected by release", n, 23);
    repeat (30) @(negedge clk);
    chk("R7 head still loaded", head_loaded, 1);
  endtask

  task automatic t_poll_irq();
    irq_ack = 1'b1;
    @(negedge clk);
    irq_ack = 1'b0;
    chk("R9 ack clears request", poll_irq, 0);
    repeat (20) @(negedge clk);
    chk("R9 request stays cleared", poll_irq, 0);
  endtask

  task automatic t_poll_mask();
    poll_en = 1'b0;
    @(negedge clk);
    chk("R8 poll_ok masked", poll_ok, 0);
    poll_en = 1'b1;
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    poll_en = 1'b0;
    @(negedge clk);
    chk("R9 request masked by poll_en", poll_irq, 0);
    poll_en = 1'b1;
    @(negedge clk);
    chk("R9 request raised again by reset", poll_irq, 1);
  endtask

  initial begin
    t_reset();
    t_poll_irq();
    t_step(3'd0, 4'hF, 12, "R2 code F 500k");
    t_step(3'd4, 4'h0, 48, "R3 code 0 2M");
    t_step(3'd1, 4'hE, 40, "R3 code E 300k");
    t_step(3'd6, 4'hF, 12, "R3 rate code 6");
    t_step_change();
    t_load(3'd0, 7'h01, 24, "R4 code 01 500k");
    t_unload(3'd4, 4'hF, 720, "R6 code F 2M");
    t_load(3'd2, 7'h00, 6144, "R4 code 00 250k");
    t_reuse();
    t_unload(3'd3, 4'hE, 1344, "R6 code E 1M");
    t_load(3'd3, 7'h7F, 1524, "R4 code 7F 1M");
    t_unload(3'd1, 4'h0, 5120, "R6 code 0 300k");
    t_release_ignored();
    t_unload(3'd2, 4'h1, 384, "R3 code 1 250k");
    t_poll_mask();
    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule